// File: doc/BRIEF.md
# Single-Channel FIFO DMA Controller

This block is a one-channel bus master for a local bus. It moves double words between the FIFO port of a bus bridge and local memory. A local processor sets it up through three write-only registers, which are selected by two high address lines: a start address, a byte count, and a control word holding an enable bit and a direction bit. Once it is enabled and the count is non-zero, the controller watches the FIFO's request line. When a request appears, it raises a hold request on the local bus. After hold acknowledge returns, it runs data phases, and each phase ends when the bus signals ready.

After each completed phase, the address advances by 4 and the count drops by 4. When the count runs out, the controller releases the bus, clears its enable bit and pulses `done`. If the FIFO withdraws its request during a transfer, the phase in progress completes and the bus is then released. Address and count are kept, so the transfer resumes on the next request.

Top module: `fifo_dma_engine`

## Requirements
- R1: After reset, `hold_req`, `bus_strobe`, `fifo_ack` and `done` are low, `bus_addr` is 0, the count is 0 and enable is clear.
- R2: With `cpu_wr` high, `cpu_sel` = 2'b01 loads the address, 2'b10 loads the byte count (both with the two low bits forced to 0) and 2'b11 loads the control word (bit 0 enable, bit 1 direction). `cpu_sel` = 2'b00 changes nothing. The registers cannot be read back; the address appears on `bus_addr`.
- R3: With enable set, a non-zero count and `fifo_req` high, `hold_req` rises on the next cycle. `bus_strobe` stays low until `hold_ack` has been sampled high, and rises on the cycle after that.
- R4: A data phase completes only in a cycle in which `bus_strobe` and `bus_ready` are both high, and `fifo_ack` is high in exactly those cycles. While ready is low, the address holds.
- R5: After each completed phase, `bus_addr` advances by 4, wrapping modulo 2^22.
- R6: The count drops by 4 per phase. On the phase that brings it to zero, `done` is high together with `fifo_ack`. On the next cycle `hold_req` is low and enable is clear, so later requests do not raise hold.
- R7: While `fifo_req` stays high, successive phases run with `bus_strobe` and `hold_req` held continuously high.
- R8: If `fifo_req` is low when a phase completes, `hold_req` drops on the next cycle. Address and count are kept, and the transfer resumes when the request returns.
- R9: During a phase, `bus_write` equals the direction bit (1 = write to memory), and it is low outside phases.
- R10: Register writes are ignored while `hold_req` is high.
- R11: If `fifo_req` falls while hold is still being awaited, `hold_req` drops on the next cycle and no phase runs.
- R12: With enable set but a zero count, a request does not raise `hold_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_sel | input | 2 | High address lines selecting the register |
| cpu_wdata | input | 22 | Register write data |
| fifo_req | input | 1 | FIFO DMA request |
| fifo_ack | output | 1 | Phase-complete pulse to the FIFO |
| hold_req | output | 1 | Local bus hold request |
| hold_ack | input | 1 | Local bus hold acknowledge |
| bus_addr | output | 22 | Transfer address |
| bus_strobe | output | 1 | Data phase active |
| bus_write | output | 1 | Direction of the active phase (1 = memory write) |
| bus_ready | input | 1 | Local bus ready, ends a phase |
| done | output | 1 | Terminal-count pulse |

## Verification
The assertions assume that `hold_ack` stays high for as long as the controller owns the bus, and that the arbiter never withdraws the grant in the middle of a phase. The bench raises `hold_ack` only in answer to `hold_req` and keeps it high until hold is released. It writes registers only at points where it intends a write to take effect, with one exception: a write made during a hold wait, which tests that such writes are ignored.

// File: rtl/fifo_dma_engine.sv
module fifo_dma_engine #(
  parameter int ADDR_W = 22,
  parameter int CNT_W  = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic [1:0]        cpu_sel,
  input  logic [ADDR_W-1:0] cpu_wdata,
  input  logic              fifo_req,
  output logic              fifo_ack,
  output logic              hold_req,
  input  logic              hold_ack,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_strobe,
  output logic              bus_write,
  input  logic              bus_ready,
  output logic              done
);
  localparam logic [1:0] SEL_ADDR = 2'b01;
  localparam logic [1:0] SEL_CNT  = 2'b10;
  localparam logic [1:0] SEL_CTRL = 2'b11;
  localparam logic [ADDR_W-1:0] ASTEP = ADDR_W'(4);
  localparam logic [CNT_W-1:0]  CSTEP = CNT_W'(4);

  typedef enum logic [1:0] {S_IDLE, S_HOLD, S_XFER} st_t;

  st_t               st;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              en_q, dir_q;

  wire busy       = (st != S_IDLE);
  wire wr_ok      = cpu_wr && !busy;
  wire phase_done = (st == S_XFER) && bus_ready;
  wire last       = (cnt_q == CSTEP);

  assign hold_req   = busy;
  assign bus_strobe = (st == S_XFER);
  assign bus_write  = bus_strobe && dir_q;
  assign bus_addr   = addr_q;
  assign fifo_ack   = phase_done;
  assign done       = phase_done && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
    end else begin
      case (st)
        S_IDLE: if (en_q && fifo_req && cnt_q != '0) st <= S_HOLD;
        S_HOLD: if (!fifo_req) st <= S_IDLE;
                else if (hold_ack) st <= S_XFER;
        S_XFER: if (bus_ready && (last || !fifo_req)) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
      en_q   <= 1'b0;
      dir_q  <= 1'b0;
    end else if (wr_ok) begin
      case (cpu_sel)
        SEL_ADDR: addr_q <= {cpu_wdata[ADDR_W-1:2], 2'b00};
        SEL_CNT:  cnt_q  <= {cpu_wdata[CNT_W-1:2], 2'b00};
        SEL_CTRL: begin
          en_q  <= cpu_wdata[0];
          dir_q <= cpu_wdata[1];
        end
        default: ;
      endcase
    end else if (phase_done) begin
      addr_q <= addr_q + ASTEP;
      cnt_q  <= cnt_q - CSTEP;
      if (last) en_q <= 1'b0;
    end
  end

  AST_STROBE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_strobe) |-> $past(hold_ack)); // R3
  AST_WAIT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_strobe && !bus_ready |=> bus_strobe && $stable(bus_addr)); // R4
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    phase_done |=> bus_addr == $past(bus_addr) + ASTEP); // R5
  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !hold_req); // R6
  AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    phase_done && fifo_req && !done |=> bus_strobe && hold_req); // R7
  AST_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    phase_done && !fifo_req |=> !hold_req); // R8
  AST_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    hold_req && cpu_wr && !phase_done |=> $stable(bus_addr)); // R10
  AST_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    hold_req && !bus_strobe && !fifo_req |=> !hold_req); // R11
endmodule

// File: tb/fifo_dma_engine_test.sv
module fifo_dma_engine_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_wr = 1'b0;
  logic [1:0] cpu_sel = 2'b00;
  logic [21:0] cpu_wdata = '0;
  logic fifo_req = 1'b0, hold_ack = 1'b0, bus_ready = 1'b0;
  logic fifo_ack, hold_req, bus_strobe, bus_write, done;
  logic [21:0] bus_addr;
  int n_chk = 0, n_bad = 0;
  bit timed_out = 0;

  always #2.5 clk = ~clk;

  fifo_dma_engine uut (.clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_sel(cpu_sel),
    .cpu_wdata(cpu_wdata), .fifo_req(fifo_req), .fifo_ack(fifo_ack), .hold_req(hold_req),
    .hold_ack(hold_ack), .bus_addr(bus_addr), .bus_strobe(bus_strobe), .bus_write(bus_write),
    .bus_ready(bus_ready), .done(done));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic wr(logic [1:0] sel, logic [21:0] d);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_sel = sel; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0; cpu_sel = 2'b00;
  endtask

  task automatic t_reset();
    chk("R1 hold_req", hold_req, 0);
    chk("R1 strobe", bus_strobe, 0);
    chk("R1 fifo_ack", fifo_ack, 0);
    chk("R1 done", done, 0);
    chk("R1 addr", bus_addr, 0);
  endtask

  task automatic t_decode();
    wr(2'b01, 22'h012347); #1;
    chk("R2 addr low bits cleared", bus_addr, 22'h012344);
    wr(2'b00, 22'h3FFFFF); #1;
    chk("R2 sel 00 no effect", bus_addr, 22'h012344);
  endtask

  task automatic t_zero();
    wr(2'b11, 22'h1);
    fifo_req = 1'b1;
    step(); step(); step();
    chk("R12 zero count no hold", hold_req, 0);
    fifo_req = 1'b0;
    wr(2'b11, 22'h0);
  endtask

  task automatic t_basic();
    wr(2'b01, 22'h100); wr(2'b10, 22'd12); wr(2'b11, 22'h3);
    @(negedge clk); fifo_req = 1'b1;
    step();
    chk("R3 hold raised", hold_req, 1);
    chk("R3 no strobe before ack", bus_strobe, 0);
    step();
    chk("R3 still waiting", bus_strobe, 0);
    hold_ack = 1'b1;
    step();
    chk("R3 strobe after ack", bus_strobe, 1);
    chk("R9 write dir", bus_write, 1);
    chk("R4 no ack without ready", fifo_ack, 0);
    step();
    chk("R4 addr held", bus_addr, 22'h100);
    bus_ready = 1'b1; #1;
    chk("R4 ack with ready", fifo_ack, 1);
    step();
    chk("R5 addr +4", bus_addr, 22'h104);
    chk("R7 strobe continuous", bus_strobe, 1);
    chk("R7 hold continuous", hold_req, 1);
    chk("R6 not done yet", done, 0);
    step();
    chk("R5 addr +8", bus_addr, 22'h108);
    chk("R6 done on last", done, 1);
    step();
    chk("R6 hold dropped", hold_req, 0);
    chk("R9 write low idle", bus_write, 0);
    chk("R5 final addr", bus_addr, 22'h10C);
    bus_ready = 1'b0;
    step(); step();
    chk("R6 enable cleared", hold_req, 0);
    fifo_req = 1'b0; hold_ack = 1'b0;
  endtask

  task automatic t_pause();
    wr(2'b01, 22'h200); wr(2'b10, 22'd16); wr(2'b11, 22'h1);
    @(negedge clk); fifo_req = 1'b1; hold_ack = 1'b1; bus_ready = 1'b1;
    step();
    chk("R8 hold", hold_req, 1);
    step();
    chk("R9 read dir", bus_write, 0);
    chk("R8 phase running", fifo_ack, 1);
    fifo_req = 1'b0;
    step();
    chk("R8 released", hold_req, 0);
    chk("R8 addr kept", bus_addr, 22'h204);
    step();
    chk("R8 stays released", hold_req, 0);
    fifo_req = 1'b1;
    step();
    chk("R8 resumes hold", hold_req, 1);
    step();
    chk("R8 resumed addr", bus_addr, 22'h204);
    chk("R8 count kept 1", done, 0);
    step();
    chk("R8 count kept 2", done, 0);
    step();
    chk("R8 last phase", bus_addr, 22'h20C);
    chk("R8 count kept done", done, 1);
    step();
    chk("R8 end hold", hold_req, 0);
    fifo_req = 1'b0; hold_ack = 1'b0; bus_ready = 1'b0;
  endtask

  task automatic t_abort();
    wr(2'b01, 22'h300); wr(2'b10, 22'd8); wr(2'b11, 22'h1);
    @(negedge clk); fifo_req = 1'b1;
    step();
    chk("R11 hold wait", hold_req, 1);
    cpu_wr = 1'b1; cpu_sel = 2'b01; cpu_wdata = 22'h3FFFFC;
    step();
    cpu_wr = 1'b0; cpu_sel = 2'b00;
    chk("R10 write ignored", bus_addr, 22'h300);
    fifo_req = 1'b0;
    step();
    chk("R11 hold dropped", hold_req, 0);
    chk("R11 no phase", bus_strobe, 0);
    fifo_req = 1'b1; hold_ack = 1'b1; bus_ready = 1'b1;
    step();
    step();
    chk("R10 addr after ignored write", bus_addr, 22'h300);
    chk("R10 count intact", done, 0);
    step();
    chk("R10 done at second", done, 1);
    step();
    fifo_req = 1'b0; hold_ack = 1'b0; bus_ready = 1'b0;
  endtask

  task automatic t_wrap();
    wr(2'b01, 22'h3FFFFC); wr(2'b10, 22'd4); wr(2'b11, 22'h1);
    @(negedge clk); fifo_req = 1'b1; hold_ack = 1'b1; bus_ready = 1'b1;
    step(); step();
    chk("R6 single phase done", done, 1);
    step();
    chk("R5 wrap", bus_addr, 22'h0);
    fifo_req = 1'b0; hold_ack = 1'b0; bus_ready = 1'b0;
  endtask

  initial begin
    #50000;
    timed_out = 1;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    t_reset();
    t_decode();
    t_zero();
    t_basic();
    t_pause();
    t_abort();
    t_wrap();
    if (!timed_out) begin
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule